// File: doc/BRIEF.md
# Serial PHY Management Master

This block runs the management side of a clause 22 PHY management link (MDC clock plus a bidirectional MDIO line). Software reaches it through a plain 32-bit register port. One register holds the transaction data. A packed command word holds the target PHY number, the register number inside the PHY, a clock divider code, a direction flag and a busy flag. When software writes a command with busy set, the block sends one 64-bit frame with MDC derived from the core clock. On a read it places the 16 bits returned by the PHY in the data register. It then clears busy by itself.

The sequencer runs through four named states. `ST_IDLE` waits for a start pulse and loads the frame. From there it goes to `ST_LOW`, where MDC is low and a new MDIO bit is presented. When the half period ends, `ST_LOW` goes to `ST_HIGH`: MDC rises and the read line is sampled. When the half period ends in `ST_HIGH`, the sequencer moves to the next bit in `ST_LOW`. After the final bit it goes to `ST_FINISH`, which runs for one cycle, loads the read result, releases busy, and always returns to `ST_IDLE`. A write value has to be in the data register before the command that starts the transaction is written. A slow MDC, such as core/128 from a 200 to 300 MHz clock, keeps MDC below 2.5 MHz.

Top module: `mgmt_serial_master`

## Requirements
- R1: After reset the command register reads 0, the data register reads 0, MDC is low and the MDIO output enable is low.
- R2: The command register sits at offset 0x48. Bit 0 is busy, bit 1 is write (1 = write, 0 = read), bits 8:4 are the PHY register number, bits 16:12 are the PHY number and bits 21:20 are the divider code. A read of it returns these fields, with zeros elsewhere.
- R3: The data register sits at offset 0x4C. A write stores the low 16 bits, and a read returns them in bits 15:0 with zeros above.
- R4: While a frame runs, MDC has a period of 16, 32, 64 or 128 core cycles for divider codes 0, 1, 2 and 3. It is high for exactly half of each period, and exactly 64 rising edges occur per frame.
- R5: A write frame carries, MSB first: 32 ones, start 01, opcode 01, the 5-bit PHY number, the 5-bit register number, turnaround 10, and then the 16 data bits from the data register. The output enable is high for all 64 bits.
- R6: A read frame carries opcode 10 and drives only its first 46 bits. The output enable is low during the turnaround and the 16 data bits.
- R7: The MDIO output and enable change only while MDC is low. They are stable from each MDC rising edge until the next falling edge.
- R8: On a read, MDIO input is sampled at the MDC rising edge of each of the last 16 bits. The result, MSB first, appears in the data register when busy clears.
- R9: Busy clears by itself, and reads 0 exactly 64×N+2 cycles after the cycle in which the command was written, where N is the MDC period in cycles. At that point MDC is low and the enable is released.
- R10: A command write while busy is set is ignored. The command read-back and the frame in flight are unchanged.
- R11: A command write with bit 0 clear stores the fields but starts no frame: busy stays 0 and MDC does not toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register byte offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register selected by reg_addr |
| mdc | output | 1 | Management clock, idle low |
| mdio_out | output | 1 | Serial data toward the PHY |
| mdio_oe | output | 1 | Output enable of the MDIO pad |
| mdio_in | input | 1 | Serial data from the pad |

## Verification
Every divider code is run in both directions. Each run measures the MDC period and the high time, and counts the cycles until busy drops, which separates the divider codes from one another and from an off-by-one in the half-period count. The PHY and register numbers are swept through all-zero, all-one and alternating patterns. This shows whether a field is misplaced, swapped or bit-reversed in the serial stream or in the read-back. A PHY model returns an inverted data pattern on reads, which separates the sampled value from the write data and detects a shifted sampling point. Separate runs write a command without busy and intrude a second command mid-frame, to confirm that neither disturbs the link.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    localparam int PREAMBLE_LEN = 32;
    localparam int HEADER_LEN   = 14;
    localparam int TA_LEN       = 2;
    localparam int DATA_LEN     = 16;
    localparam int FRAME_LEN    = PREAMBLE_LEN + HEADER_LEN + TA_LEN + DATA_LEN;
    localparam int RD_DRIVEN    = PREAMBLE_LEN + HEADER_LEN;

    localparam int PHY_W = 5;
    localparam int REG_W = 5;
    localparam int DIV_W = 2;

    localparam int BUSY_POS  = 0;
    localparam int WRITE_POS = 1;
    localparam int REG_POS   = 4;
    localparam int PHY_POS   = 12;
    localparam int DIV_POS   = 20;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PHY_W-1:0] phy;
        logic [REG_W-1:0] regad;
        logic             wr;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOW    = 2'd1,
        ST_HIGH   = 2'd2,
        ST_FINISH = 2'd3
    } mgmt_state_e;

endpackage

// File: rtl/mgmt_regs.sv
module mgmt_regs
    import mgmt_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int unsigned CMD_OFFSET  = 'h48,
    parameter int unsigned DATA_OFFSET = 'h4C
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [31:0]         wdata,
    output logic [31:0]         rdata,
    input  logic                done,
    input  logic [DATA_LEN-1:0] rd_result,
    output cmd_t                cmd,
    output logic [DATA_LEN-1:0] data,
    output logic                busy,
    output logic                start
);

    logic cmd_hit;
    logic data_hit;
    logic accept;

    assign cmd_hit  = wr_en && (addr == ADDR_W'(CMD_OFFSET));
    assign data_hit = wr_en && (addr == ADDR_W'(DATA_OFFSET));
    assign accept   = cmd_hit && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd   <= '0;
            busy  <= 1'b0;
            start <= 1'b0;
        end else begin
            start <= accept && wdata[BUSY_POS];
            if (accept) begin
                cmd.div   <= wdata[DIV_POS +: DIV_W];
                cmd.phy   <= wdata[PHY_POS +: PHY_W];
                cmd.regad <= wdata[REG_POS +: REG_W];
                cmd.wr    <= wdata[WRITE_POS];
                busy      <= wdata[BUSY_POS];
            end else if (done) begin
                busy <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
        end else if (done && !cmd.wr) begin
            data <= rd_result;
        end else if (data_hit) begin
            data <= wdata[DATA_LEN-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(CMD_OFFSET)) begin
            rdata[BUSY_POS]          = busy;
            rdata[WRITE_POS]         = cmd.wr;
            rdata[REG_POS +: REG_W]  = cmd.regad;
            rdata[PHY_POS +: PHY_W]  = cmd.phy;
            rdata[DIV_POS +: DIV_W]  = cmd.div;
        end else if (addr == ADDR_W'(DATA_OFFSET)) begin
            rdata[DATA_LEN-1:0] = data;
        end
    end

endmodule

// File: rtl/mgmt_mdc_div.sv
module mgmt_mdc_div #(
    parameter int SEL_W     = 2,
    parameter int BASE_HALF = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             half_done
);

    localparam int MAX_HALF = BASE_HALF << ((1 << SEL_W) - 1);
    localparam int CNT_W    = $clog2(MAX_HALF) + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_len;

    assign half_len  = CNT_W'(BASE_HALF) << sel;
    assign half_done = run && (cnt == half_len - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || half_done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/mgmt_frame_fsm.sv
module mgmt_frame_fsm
    import mgmt_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  cmd_t                cmd,
    input  logic [DATA_LEN-1:0] wr_data,
    input  logic                half_done,
    output logic                run,
    output logic                mdc,
    output logic                mdio_out,
    output logic                mdio_oe,
    input  logic                mdio_in,
    output logic                done,
    output logic [DATA_LEN-1:0] rd_data
);

    localparam int BIT_W = $clog2(FRAME_LEN);

    mgmt_state_e          state;
    mgmt_state_e          state_n;
    logic [FRAME_LEN-1:0] shift;
    logic [BIT_W-1:0]     bit_cnt;
    logic                 op_wr;
    logic [DATA_LEN-1:0]  rd_sh;
    logic                 last_bit;

    assign last_bit = (bit_cnt == BIT_W'(FRAME_LEN - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (start)     state_n = ST_LOW;
            ST_LOW:    if (half_done) state_n = ST_HIGH;
            ST_HIGH:   if (half_done) state_n = last_bit ? ST_FINISH : ST_LOW;
            ST_FINISH:                state_n = ST_IDLE;
            default:                  state_n = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        run      = (state == ST_LOW) || (state == ST_HIGH);
        mdc      = (state == ST_HIGH);
        mdio_oe  = run && (op_wr || (bit_cnt < BIT_W'(RD_DRIVEN)));
        mdio_out = run ? shift[FRAME_LEN-1] : 1'b1;
        done     = (state == ST_FINISH);
        rd_data  = rd_sh;
    end

    // frame shifter and read capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift   <= '0;
            bit_cnt <= '0;
            op_wr   <= 1'b0;
            rd_sh   <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                shift   <= {{PREAMBLE_LEN{1'b1}}, 2'b01,
                            (cmd.wr ? 2'b01 : 2'b10),
                            cmd.phy, cmd.regad, 2'b10, wr_data};
                bit_cnt <= '0;
                op_wr   <= cmd.wr;
            end
            if (state == ST_LOW && half_done) begin
                rd_sh <= {rd_sh[DATA_LEN-2:0], mdio_in};
            end
            if (state == ST_HIGH && half_done && !last_bit) begin
                shift   <= {shift[FRAME_LEN-2:0], 1'b0};
                bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/mgmt_serial_master.sv
module mgmt_serial_master
    import mgmt_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int unsigned CMD_OFFSET  = 'h48,
    parameter int unsigned DATA_OFFSET = 'h4C,
    parameter int          BASE_HALF   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in
);

    cmd_t                cmd_w;
    logic [DATA_LEN-1:0] data_w;
    logic [DATA_LEN-1:0] rd_w;
    logic                busy_w;
    logic                start_w;
    logic                done_w;
    logic                run_w;
    logic                half_w;

    mgmt_regs #(
        .ADDR_W      (ADDR_W),
        .CMD_OFFSET  (CMD_OFFSET),
        .DATA_OFFSET (DATA_OFFSET)
    ) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .done      (done_w),
        .rd_result (rd_w),
        .cmd       (cmd_w),
        .data      (data_w),
        .busy      (busy_w),
        .start     (start_w)
    );

    mgmt_mdc_div #(
        .SEL_W     (DIV_W),
        .BASE_HALF (BASE_HALF)
    ) div_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run_w),
        .sel       (cmd_w.div),
        .half_done (half_w)
    );

    mgmt_frame_fsm fsm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .cmd       (cmd_w),
        .wr_data   (data_w),
        .half_done (half_w),
        .run       (run_w),
        .mdc       (mdc),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .mdio_in   (mdio_in),
        .done      (done_w),
        .rd_data   (rd_w)
    );

endmodule

// File: rtl/mgmt_serial_master_chk.sv
module mgmt_serial_master_chk
    import mgmt_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int unsigned CMD_OFFSET = 'h48
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              mdc,
    input logic              mdio_out,
    input logic              mdio_oe,
    input logic              busy,
    input cmd_t              cmd
);

    // R7
    mdio_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc && $past(mdc)) |-> ($stable(mdio_out) && $stable(mdio_oe)));

    // R9
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R6
    oe_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);

    // R9
    busy_fall_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!mdio_oe && !mdc));

    // R10
    cmd_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr_en && reg_addr == ADDR_W'(CMD_OFFSET)) |=> $stable(cmd));

endmodule

bind mgmt_serial_master mgmt_serial_master_chk #(
    .ADDR_W     (ADDR_W),
    .CMD_OFFSET (CMD_OFFSET)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_addr  (reg_addr),
    .mdc       (mdc),
    .mdio_out  (mdio_out),
    .mdio_oe   (mdio_oe),
    .busy      (busy_w),
    .cmd       (cmd_w)
);

// File: tb/mgmt_serial_master_tb.sv
module mgmt_serial_master_tb_top;

    localparam logic [7:0] CMD_A  = 8'h48;
    localparam logic [7:0] DATA_A = 8'h4C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = 32'h0;
    logic [31:0] reg_rdata;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in;

    int errors = 0;
    int checks = 0;

    // monitor state
    int          cyc = 0;
    int          rise_n = 0;
    int          fall_n = 0;
    int          last_rise = 0;
    bit          period_bad = 0;
    bit          mdc_prev = 0;
    logic [63:0] seen_bits = '0;
    logic [63:0] seen_oe = '0;
    int          exp_period = 16;
    bit          mon_clear = 0;
    logic [15:0] resp = 16'h0;

    always #2 clk = ~clk;

    mgmt_serial_master dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .mdio_in   (mdio_in)
    );

    // PHY model: data bits 48..63 of a read frame, MSB first, else pulled up
    assign mdio_in = (fall_n >= 48 && fall_n < 64) ? resp[63 - fall_n] : 1'b1;

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (mon_clear) begin
            rise_n = 0; fall_n = 0; period_bad = 0;
            seen_bits = '0; seen_oe = '0; last_rise = cyc;
        end else begin
            if (mdc && !mdc_prev) begin
                if (rise_n < 64) begin
                    seen_bits[63 - rise_n] = mdio_out;
                    seen_oe[63 - rise_n]   = mdio_oe;
                end
                if (rise_n > 0 && (cyc - last_rise) != exp_period) period_bad = 1;
                last_rise = cyc;
                rise_n = rise_n + 1;
            end
            if (!mdc && mdc_prev) begin
                if ((cyc - last_rise) != exp_period / 2) period_bad = 1;
                fall_n = fall_n + 1;
            end
        end
        mdc_prev = mdc;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    function automatic logic [31:0] cmd_word(input logic [1:0] sel, input bit wr,
                                             input logic [4:0] phy, input logic [4:0] ra,
                                             input bit go);
        return {10'b0, sel, 3'b0, phy, 3'b0, ra, 2'b0, wr, go};
    endfunction

    task automatic clear_monitor();
        mon_clear = 1;
        @(negedge clk); @(negedge clk);
        mon_clear = 0;
    endtask

    task automatic run_frame(input logic [1:0] sel, input bit wr, input logic [4:0] phy,
                             input logic [4:0] ra, input logic [15:0] dat, input bit intrude);
        int          n;
        int          c;
        logic [31:0] cw;
        logic [31:0] rb;
        logic [63:0] exp_bits;
        logic [63:0] exp_oe;
        logic [63:0] mask;
        n = 16 << sel;
        exp_period = n;
        resp = ~dat;
        clear_monitor();
        if (wr) reg_write(DATA_A, {16'hDEAD, dat});
        cw = cmd_word(sel, wr, phy, ra, 1'b1);
        reg_write(CMD_A, cw);
        reg_addr = CMD_A;
        c = 0;
        while (reg_rdata[0] && c < 20000) begin
            @(negedge clk);
            c++;
            if (intrude && c == 100) begin
                reg_wr_en = 1'b1;
                reg_wdata = cmd_word(~sel, ~wr, ~phy, ~ra, 1'b1);
            end
            if (intrude && c == 101) begin
                reg_wr_en = 1'b0;
                #1;
                // R10: read-back unchanged by a write while busy
                chk(reg_rdata == cw, "R10 cmd locked", reg_rdata, cw);
            end
        end
        // R9: completion timing
        chk(c == 64 * n + 2, "R9 busy clear cycle", c, 64 * n + 2);
        chk(!mdc && !mdio_oe, "R9 released after done", {mdc, mdio_oe}, 0);
        // R4: rising edge count and period/duty
        chk(rise_n == 64, "R4 edge count", rise_n, 64);
        chk(!period_bad, "R4 mdc period", period_bad, 0);
        exp_bits = {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), phy, ra, 2'b10, dat};
        mask     = wr ? 64'hFFFF_FFFF_FFFF_FFFF : {{46{1'b1}}, 18'b0};
        exp_oe   = mask;
        if (wr) begin
            // R5: write frame content and drive
            chk(seen_bits == exp_bits, "R5 write frame", seen_bits, exp_bits);
            chk(seen_oe == exp_oe, "R5 write enable", seen_oe, exp_oe);
        end else begin
            // R6: read frame header and release
            chk((seen_bits & mask) == (exp_bits & mask), "R6 read frame", seen_bits & mask, exp_bits & mask);
            chk(seen_oe == exp_oe, "R6 read enable", seen_oe, exp_oe);
        end
        // R2: read-back fields with busy cleared
        reg_read(CMD_A, rb);
        chk(rb == (cw & ~32'h1), "R2 cmd readback", rb, cw & ~32'h1);
        reg_read(DATA_A, rb);
        if (wr) chk(rb == {16'h0, dat}, "R3 data kept", rb, {16'h0, dat});
        else    chk(rb == {16'h0, ~dat}, "R8 read result", rb, {16'h0, ~dat});
    endtask

    initial begin : main
        logic [31:0] rb;
        repeat (5) @(negedge clk);
        // R1: reset state
        reg_read(CMD_A, rb);
        chk(rb == 0, "R1 cmd reset", rb, 0);
        reg_read(DATA_A, rb);
        chk(rb == 0, "R1 data reset", rb, 0);
        chk(!mdc && !mdio_oe, "R1 pins reset", {mdc, mdio_oe}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3: only the low 16 bits are stored
        reg_write(DATA_A, 32'h1234_ABCD);
        reg_read(DATA_A, rb);
        chk(rb == 32'h0000_ABCD, "R3 data write", rb, 32'h0000_ABCD);

        // R11: command without busy starts nothing
        clear_monitor();
        reg_write(CMD_A, cmd_word(2'd2, 1'b1, 5'd19, 5'd6, 1'b0));
        repeat (300) @(negedge clk);
        reg_read(CMD_A, rb);
        chk(rb == cmd_word(2'd2, 1'b1, 5'd19, 5'd6, 1'b0), "R11 fields stored, idle", rb,
            cmd_word(2'd2, 1'b1, 5'd19, 5'd6, 1'b0));
        chk(rise_n == 0 && !mdio_oe, "R11 no toggle", rise_n, 0);

        // sweep: every divider code in both directions
        for (int s = 0; s < 4; s++) begin
            for (int w = 0; w < 2; w++) begin
                run_frame(2'(s), w[0], 5'(s * 7 + 1), 5'(30 - s * 5), 16'(16'h3C5A + s * 16'h1111 + w), 1'b0);
            end
        end
        // field patterns at the fastest divider
        run_frame(2'd0, 1'b1, 5'd31, 5'd0, 16'hFFFF, 1'b0);
        run_frame(2'd0, 1'b0, 5'd0, 5'd31, 16'h0000, 1'b0);
        run_frame(2'd0, 1'b1, 5'b10101, 5'b01010, 16'hAAAA, 1'b0);
        run_frame(2'd0, 1'b0, 5'b01010, 5'b10101, 16'h5555, 1'b0);
        // R10: intruding command during a frame
        run_frame(2'd1, 1'b1, 5'd9, 5'd17, 16'hC0DE, 1'b1);
        run_frame(2'd0, 1'b0, 5'd4, 5'd2, 16'h8001, 1'b1);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=<150000", 150000);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule